// File: doc/BRIEF.md
# SDRAM Command Encoder with Mode-Register Shadow

This block turns abstract memory requests into the command pins of a DDR3 device: clock enable, chip select, row strobe, column strobe and write enable, together with the bank and address buses. It accepts one request per clock through a valid/ready pair. It registers the request on the rising edge and drives the matching pin pattern from the next falling edge, so the pins are steady at the following rising edge. For a read or write, the column is spread across the address pins around the two flag positions, one for auto-precharge and one for burst chop.

Each load-mode request is also copied into a local shadow of the first three mode registers. From that shadow the block derives, in registers, the CAS latency, the CAS write latency, the additive latency and the total read and write latencies. For every read and write it also reports the burst length that the access uses. A controller uses these outputs to schedule the data strobes and data capture, which stay outside this block.

Top module: `sdram_cmd_issuer`

## Requirements
- R1: While reset is asserted and after it is released, cke is low and cs_n, ras_n, cas_n, we_n are high. The latency outputs read CL=4, CWL=5, AL=0, RL=4 and WL=5. req_ready goes high one clock after reset is released.
- R2: req_kind codes 0 to 7 (load-mode, refresh, precharge, activate, write, read, ZQ calibration, NOP) drive {cs_n,ras_n,cas_n,we_n} = 0000, 0001, 0010, 0011, 0100, 0101, 0110 and 0111 with cke high. Code 8 (deselect) drives cke high and all four command pins high. Codes 11 to 15 behave as NOP.
- R3: Load-mode drives ba=req_bank and a=req_addr, and stores req_addr in mode register 0, 1 or 2 as chosen by req_bank. A bank of 3 or more changes no shadow register. The latency outputs reflect a write at the rising edge after the one that accepts it.
- R4: CL = {MR0[2],MR0[6:4]} + 4 and CWL = MR2[5:3] + 5.
- R5: AL = 0 when MR1[4:3] = 0, otherwise CL − MR1[4:3]. RL = CL + AL and WL = CWL + AL.
- R6: For read and write, a[9:0] = col[9:0], a[10] = req_flag (auto-precharge), a[11] = col[10], a[12] = req_chop, a[13+k] = col[11+k], and ba = req_bank.
- R7: With each read or write, acc_bl becomes 8 when {req_chop,MR0[1:0]} is x00 or 101, and 4 when it is x1x or 001. It holds its value for other commands.
- R8: Precharge places req_flag (all banks) on a[10] with the other address bits zero and ba=req_bank. ZQ calibration places req_flag (long) on a[10] with ba=0.
- R9: Power-down (code 9) drives cke low with all command pins high. Self-refresh (code 10) drives cke low with the refresh pattern 0001 for one clock, then all command pins high. cke stays low through idle cycles after either until a request other than these two arrives.
- R10: The pins change only at the falling edge that follows the accepting rising edge. Cycles with no accepted request drive all command pins high, with cke low in a low-power state and high otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; requests sampled on rise, pins driven on fall |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block accepts a request this cycle |
| req_kind | input | 4 | Request code (see R2, R9) |
| req_bank | input | BANK_W | Bank, or mode-register select for load-mode |
| req_addr | input | ADDR_W | Row for activate, mode word for load-mode |
| req_col | input | COL_W | Column for read and write |
| req_flag | input | 1 | Auto-precharge, precharge-all or ZQ long select |
| req_chop | input | 1 | Burst-chop flag for read and write |
| cke | output | 1 | Clock enable pin |
| cs_n | output | 1 | Chip select, active low |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low |
| ba | output | BANK_W | Bank address pins |
| a | output | ADDR_W | Address pins |
| acc_bl | output | 4 | Burst length of the last read or write |
| cl | output | 5 | CAS latency |
| cwl | output | 4 | CAS write latency |
| al | output | 5 | Additive latency |
| rl | output | 6 | Read latency |
| wl | output | 6 | Write latency |

## Verification
The hardest situation to reach is the burst-length decision. It depends on a mode-register field written by an earlier request and on the chop flag of the current one, so each of its four field values needs a load-mode followed by a read or write. The stimulus rewrites MR0 with a steady CL field and a different low field each time, then issues accesses with and without chop. It also checks that the latency outputs did not move. The additive-latency subtraction is reached the same way: MR0 is written first and MR1 afterwards, so the bench sees AL follow a CL that is already in place.

// File: rtl/sdram_cmd_pkg.sv
package sdram_cmd_pkg;

   typedef enum logic [3:0] {
      RQ_LOADMODE  = 4'd0,
      RQ_REFRESH   = 4'd1,
      RQ_PRECHARGE = 4'd2,
      RQ_ACTIVATE  = 4'd3,
      RQ_WRITE     = 4'd4,
      RQ_READ      = 4'd5,
      RQ_ZQCAL     = 4'd6,
      RQ_NOP       = 4'd7,
      RQ_DESELECT  = 4'd8,
      RQ_PWRDOWN   = 4'd9,
      RQ_SELFREF   = 4'd10
   } req_kind_e;

   // {cs_n, ras_n, cas_n, we_n}
   typedef logic [3:0] pin_cmd_t;

   localparam pin_cmd_t PC_IDLE = 4'b1111;

   // Encodes an active command; low three bits of the code map onto ras/cas/we
   function automatic pin_cmd_t active_cmd(input logic [2:0] rcw);
      return {1'b0, rcw};
   endfunction

endpackage

// File: rtl/sdram_mode_shadow.sv
module sdram_mode_shadow #(
   parameter int ADDR_W = 14,
   parameter int BANK_W = 3,
   parameter int NUM_MR = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [BANK_W-1:0] wr_sel,
   input  logic [ADDR_W-1:0] wr_data,
   output logic [1:0]        mr0_blfield,
   output logic [4:0]        cl_o,
   output logic [3:0]        cwl_o,
   output logic [4:0]        al_o,
   output logic [5:0]        rl_o,
   output logic [5:0]        wl_o
);

   localparam int SEL_RANGE = 1 << BANK_W;

   if (NUM_MR < 3) begin : g_bad_mr
      $error("sdram_mode_shadow: NUM_MR must be at least 3");
   end
   if (ADDR_W < 7) begin : g_bad_aw
      $error("sdram_mode_shadow: ADDR_W too narrow for mode fields");
   end
   if (SEL_RANGE < NUM_MR) begin : g_bad_bw
      $error("sdram_mode_shadow: BANK_W cannot select every mode register");
   end

   logic [ADDR_W-1:0] mr_q [NUM_MR];

   for (genvar i = 0; i < NUM_MR; i++) begin : g_mr
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            mr_q[i] <= '0;
         else if (wr_en && (wr_sel == BANK_W'(i)))
            mr_q[i] <= wr_data;
      end

      AST_MR_UNTOUCHED: assert property (@(posedge clk) disable iff (!rst_n)
         (!wr_en || wr_sel != BANK_W'(i)) |=> $stable(mr_q[i])); // R3
   end

   logic [4:0] cl_n;
   logic [3:0] cwl_n;
   logic [4:0] al_n;
   logic [1:0] al_fld;

   always_comb begin
      cl_n   = {1'b0, mr_q[0][2], mr_q[0][6:4]} + 5'd4;
      cwl_n  = {1'b0, mr_q[2][5:3]} + 4'd5;
      al_fld = mr_q[1][4:3];
      al_n   = (al_fld == 2'b00) ? 5'd0 : (cl_n - {3'b000, al_fld});
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cl_o  <= 5'd4;
         cwl_o <= 4'd5;
         al_o  <= 5'd0;
         rl_o  <= 6'd4;
         wl_o  <= 6'd5;
      end else begin
         cl_o  <= cl_n;
         cwl_o <= cwl_n;
         al_o  <= al_n;
         rl_o  <= {1'b0, cl_n} + {1'b0, al_n};
         wl_o  <= {2'b00, cwl_n} + {1'b0, al_n};
      end
   end

   assign mr0_blfield = mr_q[0][1:0];

   AST_AL_BELOW_CL: assert property (@(posedge clk) disable iff (!rst_n)
      (al_o == 5'd0) || (al_o < cl_o)); // R5

endmodule

// File: rtl/sdram_addr_fold.sv
module sdram_addr_fold #(
   parameter int ADDR_W = 14,
   parameter int COL_W  = 12
) (
   input  logic [COL_W-1:0]  col,
   input  logic              ap,
   input  logic              bc,
   output logic [ADDR_W-1:0] a_out
);

   localparam int UPPER = COL_W - 11;

   if (ADDR_W < 13) begin : g_bad_aw
      $error("sdram_addr_fold: ADDR_W must reach the chop bit");
   end
   if (COL_W < 11) begin : g_bad_cw
      $error("sdram_addr_fold: COL_W must be at least 11");
   end
   if (UPPER > ADDR_W - 13) begin : g_bad_fit
      $error("sdram_addr_fold: upper column bits do not fit above bit 12");
   end

   always_comb begin
      a_out     = '0;
      a_out[9:0] = col[9:0];
      a_out[10] = ap;
      a_out[11] = col[10];
      a_out[12] = bc;
      for (int k = 11; k < COL_W; k++)
         a_out[k + 2] = col[k];
   end

endmodule

// File: rtl/sdram_pin_driver.sv
module sdram_pin_driver
   import sdram_cmd_pkg::*;
#(
   parameter int ADDR_W = 14,
   parameter int BANK_W = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              stg_vld,
   input  logic [3:0]        stg_kind,
   input  logic [BANK_W-1:0] stg_bank,
   input  logic [ADDR_W-1:0] stg_addr,
   input  logic [ADDR_W-1:0] stg_folded,
   input  logic              stg_flag,
   input  logic              stg_chop,
   input  logic [1:0]        mr0_blfield,
   output logic              cke_o,
   output logic              cs_n_o,
   output logic              ras_n_o,
   output logic              cas_n_o,
   output logic              we_n_o,
   output logic [BANK_W-1:0] ba_o,
   output logic [ADDR_W-1:0] a_o,
   output logic [3:0]        acc_bl_o
);

   logic     lp_q;
   pin_cmd_t cmd_q;
   logic     bl_eight;

   always_comb begin
      bl_eight = (mr0_blfield == 2'b00) || (stg_chop && mr0_blfield == 2'b01);
   end

   always_ff @(negedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cke_o    <= 1'b0;
         cmd_q    <= PC_IDLE;
         ba_o     <= '0;
         a_o      <= '0;
         lp_q     <= 1'b1;
         acc_bl_o <= 4'd0;
      end else if (!stg_vld) begin
         cke_o <= !lp_q;
         cmd_q <= PC_IDLE;
         ba_o  <= '0;
         a_o   <= '0;
      end else begin
         cke_o <= 1'b1;
         lp_q  <= 1'b0;
         ba_o  <= '0;
         a_o   <= '0;
         unique case (stg_kind)
            RQ_LOADMODE, RQ_ACTIVATE: begin
               cmd_q <= active_cmd(stg_kind[2:0]);
               ba_o  <= stg_bank;
               a_o   <= stg_addr;
            end
            RQ_REFRESH: cmd_q <= active_cmd(stg_kind[2:0]);
            RQ_PRECHARGE: begin
               cmd_q     <= active_cmd(stg_kind[2:0]);
               ba_o      <= stg_bank;
               a_o[10]   <= stg_flag;
            end
            RQ_WRITE, RQ_READ: begin
               cmd_q    <= active_cmd(stg_kind[2:0]);
               ba_o     <= stg_bank;
               a_o      <= stg_folded;
               acc_bl_o <= bl_eight ? 4'd8 : 4'd4;
            end
            RQ_ZQCAL: begin
               cmd_q   <= active_cmd(stg_kind[2:0]);
               a_o[10] <= stg_flag;
            end
            RQ_DESELECT: cmd_q <= PC_IDLE;
            RQ_PWRDOWN: begin
               cke_o <= 1'b0;
               lp_q  <= 1'b1;
               cmd_q <= PC_IDLE;
            end
            RQ_SELFREF: begin
               cke_o <= 1'b0;
               lp_q  <= 1'b1;
               cmd_q <= active_cmd(3'b001);
            end
            default: cmd_q <= active_cmd(3'b111);
         endcase
      end
   end

   assign {cs_n_o, ras_n_o, cas_n_o, we_n_o} = cmd_q;

   AST_DESELECT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      cs_n_o |-> (ras_n_o && cas_n_o && we_n_o)); // R2

   AST_LOWPOWER_FORM: assert property (@(posedge clk) disable iff (!rst_n)
      !cke_o |-> (cs_n_o || (!ras_n_o && !cas_n_o && we_n_o))); // R9

endmodule

// File: rtl/sdram_cmd_issuer.sv
module sdram_cmd_issuer
   import sdram_cmd_pkg::*;
#(
   parameter int BANK_W = 3,
   parameter int ADDR_W = 14,
   parameter int COL_W  = 12
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic [3:0]        req_kind,
   input  logic [BANK_W-1:0] req_bank,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [COL_W-1:0]  req_col,
   input  logic              req_flag,
   input  logic              req_chop,
   output logic              cke,
   output logic              cs_n,
   output logic              ras_n,
   output logic              cas_n,
   output logic              we_n,
   output logic [BANK_W-1:0] ba,
   output logic [ADDR_W-1:0] a,
   output logic [3:0]        acc_bl,
   output logic [4:0]        cl,
   output logic [3:0]        cwl,
   output logic [4:0]        al,
   output logic [5:0]        rl,
   output logic [5:0]        wl
);

   if (BANK_W < 2) begin : g_bad_bank
      $error("sdram_cmd_issuer: BANK_W must be at least 2");
   end

   logic              ready_q;
   logic              take;
   logic              stg_vld;
   logic [3:0]        stg_kind;
   logic [BANK_W-1:0] stg_bank;
   logic [ADDR_W-1:0] stg_addr;
   logic [COL_W-1:0]  stg_col;
   logic              stg_flag;
   logic              stg_chop;
   logic [ADDR_W-1:0] folded;
   logic [1:0]        mr0_blfield;

   assign take      = req_valid && ready_q;
   assign req_ready = ready_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ready_q  <= 1'b0;
         stg_vld  <= 1'b0;
         stg_kind <= 4'(RQ_NOP);
         stg_bank <= '0;
         stg_addr <= '0;
         stg_col  <= '0;
         stg_flag <= 1'b0;
         stg_chop <= 1'b0;
      end else begin
         ready_q <= 1'b1;
         stg_vld <= take;
         if (take) begin
            stg_kind <= req_kind;
            stg_bank <= req_bank;
            stg_addr <= req_addr;
            stg_col  <= req_col;
            stg_flag <= req_flag;
            stg_chop <= req_chop;
         end
      end
   end

   sdram_mode_shadow #(
      .ADDR_W (ADDR_W),
      .BANK_W (BANK_W),
      .NUM_MR (3)
   ) u_shadow (
      .clk         (clk),
      .rst_n       (rst_n),
      .wr_en       (take && req_kind == 4'(RQ_LOADMODE)),
      .wr_sel      (req_bank),
      .wr_data     (req_addr),
      .mr0_blfield (mr0_blfield),
      .cl_o        (cl),
      .cwl_o       (cwl),
      .al_o        (al),
      .rl_o        (rl),
      .wl_o        (wl)
   );

   sdram_addr_fold #(
      .ADDR_W (ADDR_W),
      .COL_W  (COL_W)
   ) u_fold (
      .col   (stg_col),
      .ap    (stg_flag),
      .bc    (stg_chop),
      .a_out (folded)
   );

   sdram_pin_driver #(
      .ADDR_W (ADDR_W),
      .BANK_W (BANK_W)
   ) u_pins (
      .clk         (clk),
      .rst_n       (rst_n),
      .stg_vld     (stg_vld),
      .stg_kind    (stg_kind),
      .stg_bank    (stg_bank),
      .stg_addr    (stg_addr),
      .stg_folded  (folded),
      .stg_flag    (stg_flag),
      .stg_chop    (stg_chop),
      .mr0_blfield (mr0_blfield),
      .cke_o       (cke),
      .cs_n_o      (cs_n),
      .ras_n_o     (ras_n),
      .cas_n_o     (cas_n),
      .we_n_o      (we_n),
      .ba_o        (ba),
      .a_o         (a),
      .acc_bl_o    (acc_bl)
   );

   AST_ACCESS_BL_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
      (!cs_n && ras_n && !cas_n) |-> (acc_bl == 4'd4 || acc_bl == 4'd8)); // R7

   AST_IDLE_DESELECT: assert property (@(posedge clk) disable iff (!rst_n)
      (!stg_vld && cke) |-> cs_n); // R10

endmodule

// File: tb/sdram_cmd_issuer_test.sv
`timescale 1ns/1ps
module sdram_cmd_issuer_test;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        req_valid;
   logic        req_ready;
   logic [3:0]  req_kind;
   logic [2:0]  req_bank;
   logic [13:0] req_addr;
   logic [11:0] req_col;
   logic        req_flag;
   logic        req_chop;
   logic        cke, cs_n, ras_n, cas_n, we_n;
   logic [2:0]  ba;
   logic [13:0] a;
   logic [3:0]  acc_bl;
   logic [4:0]  cl;
   logic [3:0]  cwl;
   logic [4:0]  al;
   logic [5:0]  rl;
   logic [5:0]  wl;

   int n_chk = 0;
   int n_bad = 0;
   bit done  = 0;

   always #2.5 clk = ~clk;

   sdram_cmd_issuer uut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
      .req_kind(req_kind), .req_bank(req_bank), .req_addr(req_addr),
      .req_col(req_col), .req_flag(req_flag), .req_chop(req_chop),
      .cke(cke), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
      .ba(ba), .a(a), .acc_bl(acc_bl), .cl(cl), .cwl(cwl), .al(al),
      .rl(rl), .wl(wl)
   );

   task automatic chk(input string req, input string what, input int act, input int exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   task automatic chk_pins(input string req, input int e_cke, input int e_cmd,
                           input int e_ba, input int e_a);
      chk(req, "cke", int'(cke), e_cke);
      chk(req, "cmd", int'({cs_n, ras_n, cas_n, we_n}), e_cmd);
      chk(req, "ba", int'(ba), e_ba);
      chk(req, "a", int'(a), e_a);
   endtask

   task automatic chk_lat(input string req, input int e_cl, input int e_cwl,
                          input int e_al, input int e_rl, input int e_wl);
      chk(req, "cl", int'(cl), e_cl);
      chk(req, "cwl", int'(cwl), e_cwl);
      chk(req, "al", int'(al), e_al);
      chk(req, "rl", int'(rl), e_rl);
      chk(req, "wl", int'(wl), e_wl);
   endtask

   // Presents a request for one cycle, returns just after the falling edge
   // where its pins appear.
   task automatic issue(input int kind, input int bank, input int addr,
                        input int col, input bit flag, input bit chop);
      @(negedge clk); #1;
      req_kind  = 4'(kind);
      req_bank  = 3'(bank);
      req_addr  = 14'(addr);
      req_col   = 12'(col);
      req_flag  = flag;
      req_chop  = chop;
      req_valid = 1'b1;
      @(posedge clk); #1;
      req_valid = 1'b0;
      @(negedge clk); #1;
   endtask

   task automatic t_reset;
      chk("R1", "cke", int'(cke), 0);
      chk("R1", "cmd", int'({cs_n, ras_n, cas_n, we_n}), 15);
      chk_lat("R1", 4, 5, 0, 4, 5);
      chk("R1", "ready", int'(req_ready), 1);
   endtask

   task automatic t_mode_latency;
      issue(0, 0, 14'h0024, 0, 0, 0);
      chk_pins("R3", 1, 4'b0000, 0, 14'h0024);
      chk_lat("R3", 4, 5, 0, 4, 5);           // not yet visible half a cycle later
      @(posedge clk); #1;
      chk_lat("R4", 14, 5, 0, 14, 5);
      issue(0, 1, 14'h0008, 0, 0, 0);
      @(posedge clk); #1;
      chk_lat("R5", 14, 5, 13, 27, 18);
      issue(0, 2, 14'h0018, 0, 0, 0);
      @(posedge clk); #1;
      chk_lat("R4", 14, 8, 13, 27, 21);
      issue(0, 1, 14'h0010, 0, 0, 0);
      @(posedge clk); #1;
      chk_lat("R5", 14, 8, 12, 26, 20);
      issue(0, 3, 14'h3FFF, 0, 0, 0);
      chk_pins("R3", 1, 4'b0000, 3, 14'h3FFF);
      @(posedge clk); #1;
      chk_lat("R3", 14, 8, 12, 26, 20);
      issue(0, 5, 14'h0000, 0, 0, 0);
      @(posedge clk); #1;
      chk_lat("R3", 14, 8, 12, 26, 20);
   endtask

   task automatic t_access_fold;
      // col[11]=1, col[10]=1, col[9:0]=0x1A5
      issue(4, 6, 0, 12'hDA5, 1, 0);
      chk_pins("R6", 1, 4'b0100, 6, 14'h2DA5);
      chk("R7", "bl", int'(acc_bl), 8);
      issue(5, 2, 0, 12'h3FF, 0, 1);
      chk_pins("R6", 1, 4'b0101, 2, 14'h13FF);
      chk("R7", "bl", int'(acc_bl), 8);
      issue(5, 1, 0, 12'h400, 1, 1);
      chk_pins("R6", 1, 4'b0101, 1, 14'h1C00);
   endtask

   task automatic t_burst_len;
      issue(0, 0, 14'h0025, 0, 0, 0);        // BL field 01
      issue(5, 0, 0, 0, 0, 1);
      chk("R7", "bl 101", int'(acc_bl), 8);
      issue(4, 0, 0, 0, 0, 0);
      chk("R7", "bl 001", int'(acc_bl), 4);
      issue(7, 0, 0, 0, 0, 0);
      chk("R7", "bl held", int'(acc_bl), 4);
      issue(0, 0, 14'h0026, 0, 0, 0);        // BL field 10
      issue(5, 0, 0, 0, 0, 1);
      chk("R7", "bl 110", int'(acc_bl), 4);
      issue(0, 0, 14'h0027, 0, 0, 0);        // BL field 11
      issue(4, 0, 0, 0, 0, 0);
      chk("R7", "bl 011", int'(acc_bl), 4);
      issue(0, 0, 14'h0024, 0, 0, 0);        // BL field 00
      issue(4, 0, 0, 0, 0, 1);
      chk("R7", "bl 100", int'(acc_bl), 8);
      @(posedge clk); #1;
      chk("R4", "cl kept", int'(cl), 14);
   endtask

   task automatic t_misc_cmds;
      issue(1, 5, 14'h1234, 0, 1, 1);
      chk_pins("R2", 1, 4'b0001, 0, 0);
      issue(3, 4, 14'h2ABC, 0, 0, 0);
      chk_pins("R2", 1, 4'b0011, 4, 14'h2ABC);
      issue(2, 7, 14'h3FFF, 0, 1, 0);
      chk_pins("R8", 1, 4'b0010, 7, 14'h0400);
      issue(2, 3, 0, 0, 0, 0);
      chk_pins("R8", 1, 4'b0010, 3, 0);
      issue(6, 5, 14'h3FFF, 0, 1, 0);
      chk_pins("R8", 1, 4'b0110, 0, 14'h0400);
      issue(7, 0, 0, 0, 0, 0);
      chk_pins("R2", 1, 4'b0111, 0, 0);
      issue(13, 0, 0, 0, 0, 0);
      chk_pins("R2", 1, 4'b0111, 0, 0);
      issue(8, 0, 0, 0, 0, 0);
      chk_pins("R2", 1, 4'b1111, 0, 0);
      @(negedge clk); #1;
      chk_pins("R10", 1, 4'b1111, 0, 0);
   endtask

   task automatic t_low_power;
      issue(9, 0, 0, 0, 0, 0);
      chk_pins("R9", 0, 4'b1111, 0, 0);
      @(negedge clk); #1;
      chk_pins("R9", 0, 4'b1111, 0, 0);
      issue(7, 0, 0, 0, 0, 0);
      chk_pins("R9", 1, 4'b0111, 0, 0);
      issue(10, 0, 0, 0, 0, 0);
      chk_pins("R9", 0, 4'b0001, 0, 0);
      @(negedge clk); #1;
      chk_pins("R9", 0, 4'b1111, 0, 0);
      @(negedge clk); #1;
      chk_pins("R9", 0, 4'b1111, 0, 0);
      issue(8, 0, 0, 0, 0, 0);
      chk_pins("R9", 1, 4'b1111, 0, 0);
   endtask

   task automatic t_edge_timing;
      // Pins must not move at the accepting rising edge, only at the next fall
      @(negedge clk); #1;
      req_kind = 4'd1; req_bank = 0; req_addr = 0; req_col = 0;
      req_flag = 0; req_chop = 0; req_valid = 1'b1;
      @(posedge clk); #1;
      req_valid = 1'b0;
      chk("R10", "cmd before fall", int'({cs_n, ras_n, cas_n, we_n}), 15);
      @(negedge clk); #1;
      chk("R10", "cmd after fall", int'({cs_n, ras_n, cas_n, we_n}), 1);
   endtask

   initial begin
      rst_n = 1'b0; req_valid = 1'b0; req_kind = 4'd7; req_bank = '0;
      req_addr = '0; req_col = '0; req_flag = 1'b0; req_chop = 1'b0;
      repeat (3) @(posedge clk);
      #1;
      chk("R1", "cke in reset", int'(cke), 0);
      chk("R1", "cs_n in reset", int'(cs_n), 1);
      @(negedge clk); rst_n = 1'b1;
      repeat (2) @(posedge clk);
      #1;
      t_reset();
      t_mode_latency();
      t_access_fold();
      t_burst_len();
      t_misc_cmds();
      t_low_power();
      t_edge_timing();
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog: actual hung expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end

endmodule